// File: doc/BRIEF.md
# Address Decoder with Boot Remap

This block turns a 32-bit processor address into one of three region selects: on-chip memory in the lowest window, on-chip peripherals in the highest window, and the external bus for everything in between. The selects are combinational and gated by an address-valid strobe. At most one select is high in any cycle.

The lowest window also has a boot remap. After reset, an access there is routed to chip select 0, where the nonvolatile boot device holding the reset vector sits. After software issues a one-cycle remap pulse, the same window is routed to the on-chip SRAM instead. This makes the exception vectors writable. The boot device stays reachable at its own address range in external space.

While reset is held low, the block samples a boot-mode pin every clock. It keeps the majority of the last samples taken before reset is released, and holds that value as the external boot data-bus width until the next reset. All regions use little-endian byte order; the decode does not depend on byte order.

Top module: `addr_remap_decoder`

## Requirements
- R1: With valid high, an address whose bits [31:22] are all zero asserts `sel_int_o` only.
- R2: With valid high, an address whose bits [31:22] are all one asserts `sel_periph_o` only.
- R3: With valid high, any other address asserts `sel_ext_o` only.
- R4: With valid low, `sel_int_o`, `sel_ext_o`, `sel_periph_o`, `cs0_req_o` and `sram_sel_o` are all low.
- R5: Before a remap, a valid access to the lowest window asserts `cs0_req_o` and keeps `sram_sel_o` low.
- R6: From the first clock edge that samples `remap_i` high onward, a valid access to the lowest window asserts `sram_sel_o` and keeps `cs0_req_o` low.
- R7: The remap state is sticky. Further pulses change nothing, and only reset returns the block to the boot mapping.
- R8: A valid access in the 4 MB window starting at 0x0100_0000 asserts `cs0_req_o` whether or not a remap has happened.
- R9: `boot_bus8_o` is 1 (8-bit boot device) when at least 6 of the last 10 `boot_mode_i` samples taken at rising clock edges while `rst_ni` is low are 1. Otherwise it is 0 (16-bit boot device); a 5/5 tie gives 0.
- R10: After `rst_ni` rises, `boot_bus8_o` holds its value whatever `boot_mode_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; boot-mode sampling window |
| addr_i | input | 32 | Processor address |
| valid_i | input | 1 | Address-valid strobe |
| boot_mode_i | input | 1 | Boot-mode pin |
| remap_i | input | 1 | One-cycle remap command |
| sel_int_o | output | 1 | Internal memory region select |
| sel_ext_o | output | 1 | External bus region select |
| sel_periph_o | output | 1 | Internal peripheral region select |
| cs0_req_o | output | 1 | Chip select 0 request |
| sram_sel_o | output | 1 | On-chip SRAM target for the lowest window |
| boot_bus8_o | output | 1 | Latched boot width, 1 = 8-bit, 0 = 16-bit |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 4 MB edge windows, a chip-select-0 alias at 0x0100_0000, and a 10-sample boot window. With these values the exact window boundaries (0x003F_FFFF/0x0040_0000, 0xFFBF_FFFF/0xFFC0_0000, and both edges of the alias) can be driven directly alongside random addresses. The 10-sample window makes the 5/5 tie and the 6/4 majority reachable with short reset pulses. Samples placed before the window check that only the final 10 count.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  typedef enum logic [1:0] {
    REG_INT    = 2'd0,
    REG_EXT    = 2'd1,
    REG_PERIPH = 2'd2
  } region_e;
endpackage

// File: rtl/region_decode.sv
module region_decode
  import addr_dec_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int WIN_LOG2     = 22,
  parameter logic [ADDR_W-1:0] CS0_BASE = 32'h0100_0000,
  parameter int CS0_WIN_LOG2 = 22
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic              cs0_alias_o
);
  localparam int TAG_W = ADDR_W - WIN_LOG2;
  localparam int CS0_TAG_W = ADDR_W - CS0_WIN_LOG2;

  logic [TAG_W-1:0] tag;
  assign tag = addr_i[ADDR_W-1:WIN_LOG2];

  always_comb begin
    if (tag == '0)      region_o = REG_INT;
    else if (&tag)      region_o = REG_PERIPH;
    else                region_o = REG_EXT;
  end

  assign cs0_alias_o = (addr_i[ADDR_W-1:CS0_WIN_LOG2] == CS0_BASE[ADDR_W-1:CS0_WIN_LOG2])
                       && (CS0_TAG_W > 0);
endmodule

// File: rtl/remap_flag.sv
module remap_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic remap_i,
  output logic remapped_o
);
  logic remap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      remap_q <= 1'b0;
    else if (remap_i) remap_q <= 1'b1;
  end

  assign remapped_o = remap_q;

  AST_REMAP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap_q |=> remap_q); // R7
  AST_REMAP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap_i |=> remapped_o); // R6
endmodule

// File: rtl/boot_width_capture.sv
module boot_width_capture #(
  parameter int SAMPLES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic boot_mode_i,
  output logic bus8_o
);
  localparam int CNT_W = $clog2(SAMPLES + 1);

  logic [SAMPLES-1:0] win_q;
  logic [SAMPLES-1:0] win_d;
  logic [CNT_W-1:0]   ones;
  logic               bus8_q;

  assign win_d = {win_q[SAMPLES-2:0], boot_mode_i};

  always_comb begin
    ones = '0;
    for (int i = 0; i < SAMPLES; i++) ones = ones + CNT_W'(win_d[i]);
  end

  // Sampling runs only while reset is held; values freeze on release.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      win_q  <= win_d;
      bus8_q <= (int'(ones) > SAMPLES / 2);
    end
  end

  assign bus8_o = bus8_q;

  AST_WIDTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(bus8_o)); // R10
endmodule

// File: rtl/addr_remap_decoder.sv
module addr_remap_decoder
  import addr_dec_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int WIN_LOG2     = 22,
  parameter logic [ADDR_W-1:0] CS0_BASE = 32'h0100_0000,
  parameter int CS0_WIN_LOG2 = 22,
  parameter int BOOT_SAMPLES = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              valid_i,
  input  logic              boot_mode_i,
  input  logic              remap_i,
  output logic              sel_int_o,
  output logic              sel_ext_o,
  output logic              sel_periph_o,
  output logic              cs0_req_o,
  output logic              sram_sel_o,
  output logic              boot_bus8_o
);
  region_e region;
  logic    cs0_alias;
  logic    remapped;

  region_decode #(
    .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2),
    .CS0_BASE(CS0_BASE), .CS0_WIN_LOG2(CS0_WIN_LOG2)
  ) u_dec (
    .addr_i(addr_i), .region_o(region), .cs0_alias_o(cs0_alias)
  );

  remap_flag u_remap (
    .clk_i(clk_i), .rst_ni(rst_ni), .remap_i(remap_i), .remapped_o(remapped)
  );

  boot_width_capture #(.SAMPLES(BOOT_SAMPLES)) u_boot (
    .clk_i(clk_i), .rst_ni(rst_ni), .boot_mode_i(boot_mode_i), .bus8_o(boot_bus8_o)
  );

  assign sel_int_o    = valid_i && (region == REG_INT);
  assign sel_ext_o    = valid_i && (region == REG_EXT);
  assign sel_periph_o = valid_i && (region == REG_PERIPH);

  // Low window targets boot device until remap, then SRAM.
  assign sram_sel_o = sel_int_o && remapped;
  assign cs0_req_o  = (sel_int_o && !remapped) || (sel_ext_o && cs0_alias);

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $onehot({sel_int_o, sel_ext_o, sel_periph_o})); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !(sel_int_o || sel_ext_o || sel_periph_o || cs0_req_o || sram_sel_o)); // R4
  AST_TARGET_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_sel_o && cs0_req_o)); // R6
  AST_BOOT_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_int_o && !remapped) |-> cs0_req_o); // R5
endmodule

// File: tb/addr_remap_decoder_tb_top.sv
module addr_remap_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic        valid = 1'b0;
  logic        bmode = 1'b0;
  logic        remap = 1'b0;
  logic        s_int, s_ext, s_per, cs0, sram, bus8;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          rem_model = 1'b0;

  always #10 clk = ~clk;

  addr_remap_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .valid_i(valid),
    .boot_mode_i(bmode), .remap_i(remap),
    .sel_int_o(s_int), .sel_ext_o(s_ext), .sel_periph_o(s_per),
    .cs0_req_o(cs0), .sram_sel_o(sram), .boot_bus8_o(bus8)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h actual=%b expected=%b", req, addr, act, exp);
    end
  endtask

  function automatic logic [4:0] expect_sel(input logic [31:0] a, input bit v, input bit rm);
    logic i, e, p, c, s;
    i = v && (a[31:22] == 10'h000);
    p = v && (a[31:22] == 10'h3FF);
    e = v && !i && !p;
    c = (i && !rm) || (e && a[31:22] == 10'h004);
    s = i && rm;
    return {i, e, p, c, s};
  endfunction

  task automatic probe(input logic [31:0] a, input bit v, input string req);
    @(negedge clk);
    addr = a; valid = v;
    #1;
    check(req, {3'b0, s_int, s_ext, s_per, cs0, sram}, {3'b0, expect_sel(a, v, rem_model)});
  endtask

  task automatic boot_reset(input logic [9:0] pat, input bit pre);
    @(negedge clk);
    rst_n = 1'b0; rem_model = 1'b0;
    for (int k = 0; k < 12; k++) begin
      bmode = (k < 2) ? pre : pat[k-2];
      @(negedge clk);
    end
    rst_n = 1'b1;
  endtask

  function automatic bit expect_w(input logic [9:0] pat);
    return $countones(pat) >= 6;
  endfunction

  task automatic do_remap();
    @(negedge clk);
    remap = 1'b1;
    @(negedge clk);
    remap = 1'b0;
    rem_model = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [9:0]  pats [4];
    void'($urandom(32'd1234));
    pats[0] = 10'b11_1111_1111; pats[1] = 10'b10_1010_1010;
    pats[2] = 10'b11_0110_1010; pats[3] = 10'b00_0000_0000;

    // R9 majority capture and R10 hold
    for (int t = 0; t < 4; t++) begin
      boot_reset(pats[t], 1'b1);
      @(negedge clk); #1;
      check("R9 width", {7'b0, bus8}, {7'b0, expect_w(pats[t])});
      bmode = ~bmode;
      repeat (3) @(negedge clk);
      bmode = ~bmode;
      #1;
      check("R10 hold", {7'b0, bus8}, {7'b0, expect_w(pats[t])});
    end

    // Reset state: R4 quiet outputs with valid low
    probe(32'h0000_0000, 1'b0, "R4 idle");
    // R1/R5 boundaries before remap
    probe(32'h0000_0000, 1'b1, "R5 boot vector");
    probe(32'h003F_FFFF, 1'b1, "R1 int top");
    probe(32'h0040_0000, 1'b1, "R3 ext bottom");
    probe(32'hFFBF_FFFF, 1'b1, "R3 ext top");
    probe(32'hFFC0_0000, 1'b1, "R2 periph bottom");
    probe(32'hFFFF_FFFF, 1'b1, "R2 periph top");
    probe(32'h0100_0000, 1'b1, "R8 alias low");
    probe(32'h013F_FFFF, 1'b1, "R8 alias high");
    probe(32'h0140_0000, 1'b1, "R8 alias outside");
    for (int k = 0; k < 40; k++) begin
      r = $urandom;
      if (k % 4 == 0) r[31:22] = 10'h000;
      probe(r, k % 7 != 3, "R3 random pre");
    end

    // R6 remap, R7 sticky
    do_remap();
    probe(32'h0000_0020, 1'b1, "R6 vector to sram");
    probe(32'h0100_0004, 1'b1, "R8 alias after remap");
    do_remap();
    probe(32'h0000_0000, 1'b1, "R7 second pulse");
    for (int k = 0; k < 40; k++) begin
      r = $urandom;
      if (k % 3 == 0) r[31:22] = (k % 2) ? 10'h3FF : 10'h000;
      probe(r, k % 5 != 2, "R1 random post");
    end
    probe(32'h0012_3456, 1'b0, "R4 idle post");

    // R7 only reset clears remap
    boot_reset(10'b00_0000_0001, 1'b0);
    probe(32'h0000_0000, 1'b1, "R7 reset clears");
    check("R9 tail", {7'b0, bus8}, 8'd0);
    finish_run();
  end
endmodule